// File: doc/BRIEF.md
# CAN bit timing unit

This block cuts the time on a CAN bus into bits and cuts each bit into its segments. It captures a packed 32-bit timing word while a configuration input is high. It divides the module clock by the prescaler held in that word to make a time quantum. Each bit then runs through three phases, held in the state register: SYNC (one quantum), SEG1 (propagation plus phase-1 time) and SEG2 (phase-2 time, which must cover the information processing time). The length of a bit is 1 + TSEG1 + TSEG2 quanta.

The surrounding controller takes three outputs. A sample strobe marks the end of SEG1, and the sampled bus level is shown on `rx_bit`. A transmit strobe marks the start of each new bit. The unit also follows the bus. A recessive-to-dominant edge seen while the controller reports an idle bus restarts the bit, which is a hard synchronization. Later edges move the bit boundary by at most the jump width, which is resynchronization.

The state machine has three states and these transitions:
- SYNC_TO_SEG1 at the end of the sync quantum.
- SEG1_TO_SEG2 when the SEG1 limit is reached; the sample strobe fires here.
- SEG2_TO_SYNC when the SEG2 limit is reached; the transmit strobe fires here.
- ANY_TO_SEG1 on a hard synchronization.
- CFG_TO_SYNC, where configuration holds the machine in SYNC.

Top module: `can_bit_timer`

## Requirements
- R1: The timing word fields are: prescaler-1 in bits 5:0, jump width-1 in bits 7:6, TSEG1-1 in bits 11:8 and TSEG2-1 in bits 14:12. All other bits are ignored. The word is captured on every clock while `cfg_en` is high; for example 0x000024C1 gives prescaler 2, jump width 4, TSEG1 5 and TSEG2 3.
- R2: In every cycle after a clock edge that saw `cfg_en` high, `phase` is SYNC (0), and `tq_strobe`, `sample_pulse` and `tx_pulse` are low.
- R3: `tq_strobe` is high for one clock in every prescaler clocks. It first goes high in the prescaler-th cycle after the first edge that sees `cfg_en` low.
- R4: `phase` is encoded as SYNC = 0, SEG1 = 1 and SEG2 = 2, and changes only on a clock edge where `tq_strobe` is high. With no bus edges it runs SYNC for 1 quantum, SEG1 for TSEG1 quanta and SEG2 for TSEG2 quanta. So 0x24C1 gives a bit of 18 clocks.
- R5: `sample_pulse` is high for the one cycle after the edge that ends SEG1. On that edge `rx_bit` takes `bus_rx`.
- R6: `tx_pulse` is high for the one cycle after the edge that ends SEG2, when SYNC begins.
- R7: A bus edge is detected at a quantum tick when `bus_rx` is 0 and was 1 at the previous tick. A held level is never an edge.
- R8: An edge while `bus_idle` is 1 sends the machine to SEG1 with a fresh TSEG1 count. It emits no strobe and uses up the resynchronization allowance.
- R9: An edge with `bus_idle` 0 in the k-th quantum of SEG1 (k from 1) lengthens SEG1 to TSEG1 + min(k, jump width) quanta.
- R10: An edge with `bus_idle` 0 in the k-th quantum of SEG2 shortens SEG2 to max(k, TSEG2 − jump width) quanta.
- R11: Only one resynchronization acts between two sample points. Further edges in that span, and any edge in SYNC with `bus_idle` 0, change nothing.
- R12: While `rst_n` is low, `phase` is 0, all strobes are low and `rx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | module clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cfg_en | input | 1 | configuration enable; holds the timer and captures the word |
| cfg_word | input | 32 | packed timing word |
| bus_rx | input | 1 | receive level, 1 = recessive |
| bus_idle | input | 1 | high when the controller allows hard synchronization |
| tq_strobe | output | 1 | one-cycle quantum tick |
| sample_pulse | output | 1 | one-cycle strobe after the sample point |
| tx_pulse | output | 1 | one-cycle strobe at the start of a bit |
| rx_bit | output | 1 | bus level captured at the last sample point |
| phase | output | 2 | current segment: 0 SYNC, 1 SEG1, 2 SEG2 |

## Verification
The assertions assume that `bus_rx` and `bus_idle` are stable around the clock edge. They also assume the timing word does not change while `cfg_en` is low, since the word is only captured while `cfg_en` is high. The stimulus changes every input on the falling edge. It changes `cfg_word` only inside a configuration window. It toggles the bus at random only while a configuration is in force, so edges fall in every segment, with and without the idle flag.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    localparam int BRP_W  = 6;
    localparam int SJW_W  = 2;
    localparam int TS1_W  = 4;
    localparam int TS2_W  = 3;
    localparam int CFG_W  = 32;
    // quantum counter must hold TSEG1 max plus jump width max
    localparam int QCNT_W = TS1_W + 2;

    localparam int SJW_LO = BRP_W;
    localparam int TS1_LO = SJW_LO + SJW_W;
    localparam int TS2_LO = TS1_LO + TS1_W;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_SEG1 = 2'd1,
        PH_SEG2 = 2'd2
    } phase_t;

    typedef struct packed {
        logic [TS2_W-1:0] ts2_m1;
        logic [TS1_W-1:0] ts1_m1;
        logic [SJW_W-1:0] sjw_m1;
        logic [BRP_W-1:0] brp_m1;
    } timing_t;

    function automatic timing_t unpack_word(input logic [CFG_W-1:0] w);
        timing_t t;
        t.brp_m1 = w[BRP_W-1:0];
        t.sjw_m1 = w[SJW_LO +: SJW_W];
        t.ts1_m1 = w[TS1_LO +: TS1_W];
        t.ts2_m1 = w[TS2_LO +: TS2_W];
        return t;
    endfunction
endpackage

// File: rtl/cbt_quantum_gen.sv
module cbt_quantum_gen
    import cbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [CFG_W-1:0] cfg_word,
    output timing_t          cfg,
    output logic             tick,
    output logic             running
);
    logic [BRP_W-1:0] cnt;

    assign tick = running && (cnt == cfg.brp_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg     <= '0;
            running <= 1'b0;
            cnt     <= '0;
        end else if (cfg_en) begin
            cfg     <= unpack_word(cfg_word);
            running <= 1'b0;
            cnt     <= '0;
        end else if (!running) begin
            running <= 1'b1;
        end else begin
            cnt <= tick ? '0 : cnt + BRP_W'(1);
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cfg.brp_m1 != '0) |=> !tick); // R3
endmodule

// File: rtl/cbt_edge_watch.sv
module cbt_edge_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic tick,
    input  logic bus_rx,
    input  logic bus_idle,
    output logic edge_o,
    output logic hsync_o
);
    logic last_lvl;

    assign edge_o  = tick && last_lvl && !bus_rx;
    assign hsync_o = edge_o && bus_idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       last_lvl <= 1'b1;
        else if (hold)    last_lvl <= 1'b1;
        else if (tick)    last_lvl <= bus_rx;
    end

    AST_EDGE_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n || hold)
        (edge_o) |=> !edge_o || !tick || bus_rx); // R7
endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
    import cbt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hold,
    input  timing_t cfg,
    input  logic    tick,
    input  logic    edge_i,
    input  logic    hsync_i,
    input  logic    bus_rx,
    output phase_t  state,
    output logic    sample_pulse,
    output logic    tx_pulse,
    output logic    rx_bit
);
    logic [QCNT_W-1:0] q, q_n, qn, lim, lim_n, lim_c, err, adj;
    logic [QCNT_W-1:0] ts1, ts2, sjw;
    logic              ok, ok_n, samp_n, tx_n;
    phase_t            state_n;

    assign ts1 = QCNT_W'(cfg.ts1_m1) + QCNT_W'(1);
    assign ts2 = QCNT_W'(cfg.ts2_m1) + QCNT_W'(1);
    assign sjw = QCNT_W'(cfg.sjw_m1) + QCNT_W'(1);
    assign qn  = q + QCNT_W'(1);

    always_comb begin
        state_n = state;
        q_n     = q;
        lim_n   = lim;
        ok_n    = ok;
        samp_n  = 1'b0;
        tx_n    = 1'b0;
        lim_c   = lim;
        err     = '0;
        adj     = '0;
        if (tick) begin
            if (hsync_i) begin
                state_n = PH_SEG1;
                q_n     = '0;
                lim_n   = ts1;
                ok_n    = 1'b0;
            end else begin
                unique case (state)
                    PH_SYNC: begin
                        state_n = PH_SEG1;
                        q_n     = '0;
                        lim_n   = ts1;
                    end
                    PH_SEG1: begin
                        if (edge_i && ok) begin
                            adj   = (qn < sjw) ? qn : sjw;
                            lim_c = ts1 + adj;
                            ok_n  = 1'b0;
                        end
                        if (qn >= lim_c) begin
                            state_n = PH_SEG2;
                            q_n     = '0;
                            lim_n   = ts2;
                            samp_n  = 1'b1;
                            ok_n    = 1'b1;
                        end else begin
                            q_n   = qn;
                            lim_n = lim_c;
                        end
                    end
                    PH_SEG2: begin
                        if (edge_i && ok) begin
                            err   = ts2 - qn;
                            adj   = (err < sjw) ? err : sjw;
                            lim_c = ts2 - adj;
                            ok_n  = 1'b0;
                        end
                        if (qn >= lim_c) begin
                            state_n = PH_SYNC;
                            q_n     = '0;
                            tx_n    = 1'b1;
                        end else begin
                            q_n   = qn;
                            lim_n = lim_c;
                        end
                    end
                    default: state_n = PH_SYNC;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_SYNC;
            q     <= '0;
            lim   <= '0;
            ok    <= 1'b1;
        end else if (hold) begin
            state <= PH_SYNC;
            q     <= '0;
            lim   <= '0;
            ok    <= 1'b1;
        end else begin
            state <= state_n;
            q     <= q_n;
            lim   <= lim_n;
            ok    <= ok_n;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_pulse <= 1'b0;
            tx_pulse     <= 1'b0;
            rx_bit       <= 1'b1;
        end else if (hold) begin
            sample_pulse <= 1'b0;
            tx_pulse     <= 1'b0;
            rx_bit       <= 1'b1;
        end else begin
            sample_pulse <= samp_n;
            tx_pulse     <= tx_n;
            if (samp_n) rx_bit <= bus_rx;
        end
    end

    AST_ADV_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !hold) |=> $stable(state)); // R4
    AST_SEG2_NOT_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hsync_i && !hold && state == PH_SEG2) |=> state != PH_SEG1); // R4
    AST_SAMPLE_AFTER_SEG1: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pulse |-> $past(state) == PH_SEG1 && state == PH_SEG2); // R5
    AST_TX_AFTER_SEG2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pulse |-> $past(state) == PH_SEG2 && state == PH_SYNC); // R6
    AST_HSYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hsync_i && !hold) |=> state == PH_SEG1 && !sample_pulse && !tx_pulse); // R8
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_pulse && tx_pulse)); // R6
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import cbt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_en,
    input  logic [31:0] cfg_word,
    input  logic        bus_rx,
    input  logic        bus_idle,
    output logic        tq_strobe,
    output logic        sample_pulse,
    output logic        tx_pulse,
    output logic        rx_bit,
    output logic [1:0]  phase
);
    timing_t cfg;
    logic    tick, running, edge_s, hsync_s;
    phase_t  st;

    cbt_quantum_gen u_qgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_word (cfg_word),
        .cfg      (cfg),
        .tick     (tick),
        .running  (running)
    );

    cbt_edge_watch u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (cfg_en),
        .tick     (tick),
        .bus_rx   (bus_rx),
        .bus_idle (bus_idle),
        .edge_o   (edge_s),
        .hsync_o  (hsync_s)
    );

    cbt_seg_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold         (cfg_en),
        .cfg          (cfg),
        .tick         (tick),
        .edge_i       (edge_s),
        .hsync_i      (hsync_s),
        .bus_rx       (bus_rx),
        .state        (st),
        .sample_pulse (sample_pulse),
        .tx_pulse     (tx_pulse),
        .rx_bit       (rx_bit)
    );

    assign tq_strobe = tick;
    assign phase     = st;

    AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (phase == 2'd0 && !sample_pulse && !tx_pulse && !tq_strobe && !running)); // R2
endmodule

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, cfg_en, bus_rx, bus_idle;
    logic [31:0] cfg_word;
    logic        tq_strobe, sample_pulse, tx_pulse, rx_bit;
    logic [1:0]  phase;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_bit_timer uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_word(cfg_word),
        .bus_rx(bus_rx), .bus_idle(bus_idle), .tq_strobe(tq_strobe),
        .sample_pulse(sample_pulse), .tx_pulse(tx_pulse), .rx_bit(rx_bit),
        .phase(phase)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference model
    int m_brp = 1, m_sjw = 1, m_t1 = 1, m_t2 = 1;
    int m_cnt = 0, m_st = 0, m_q = 0, m_lim = 0;
    bit m_ok = 1, m_prev = 1, m_run = 0, m_sp = 0, m_tp = 0, m_rx = 1;
    string m_tag = "R12";
    int n_edges = 0, n_hs = 0, n_r1 = 0, n_r2 = 0, n_ign = 0;

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic model_clear();
        m_run = 0; m_cnt = 0; m_st = 0; m_q = 0; m_lim = 0;
        m_ok = 1; m_prev = 1; m_sp = 0; m_tp = 0; m_rx = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_brp = 1; m_sjw = 1; m_t1 = 1; m_t2 = 1;
            model_clear();
            m_tag = "R12";
        end else if (cfg_en) begin
            m_brp = cfg_word[5:0] + 1;
            m_sjw = cfg_word[7:6] + 1;
            m_t1  = cfg_word[11:8] + 1;
            m_t2  = cfg_word[14:12] + 1;
            model_clear();
            m_tag = "R2";
        end else if (!m_run) begin
            m_run = 1; m_sp = 0; m_tp = 0;
        end else begin
            bit tk, e;
            int qn, l;
            tk = (m_cnt == m_brp - 1);
            m_sp = 0; m_tp = 0;
            if (tk) begin
                e = m_prev && !bus_rx;
                m_prev = bus_rx;
                qn = m_q + 1;
                if (e) n_edges++;
                if (e && bus_idle) begin
                    m_st = 1; m_q = 0; m_lim = m_t1; m_ok = 0; n_hs++; m_tag = "R8";
                end else if (m_st == 0) begin
                    m_st = 1; m_q = 0; m_lim = m_t1;
                    if (e) begin n_ign++; m_tag = "R11"; end else m_tag = "R4";
                end else if (m_st == 1) begin
                    l = m_lim;
                    if (e && m_ok) begin
                        l = m_t1 + imin(qn, m_sjw); m_ok = 0; n_r1++; m_tag = "R9";
                    end else if (e) begin
                        n_ign++; m_tag = "R11";
                    end
                    if (qn >= l) begin
                        m_st = 2; m_q = 0; m_lim = m_t2; m_sp = 1; m_rx = bus_rx; m_ok = 1;
                    end else begin
                        m_q = qn; m_lim = l;
                    end
                end else begin
                    l = m_lim;
                    if (e && m_ok) begin
                        l = m_t2 - imin(m_t2 - qn, m_sjw); m_ok = 0; n_r2++; m_tag = "R10";
                    end else if (e) begin
                        n_ign++; m_tag = "R11";
                    end
                    if (qn >= l) begin
                        m_st = 0; m_q = 0; m_tp = 1;
                    end else begin
                        m_q = qn; m_lim = l;
                    end
                end
                m_cnt = 0;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R3 tq_strobe", int'(tq_strobe), int'(m_run && (m_cnt == m_brp - 1)));
            check("R5 sample_pulse", int'(sample_pulse), int'(m_sp));
            check("R5 rx_bit", int'(rx_bit), int'(m_rx));
            check("R6 tx_pulse", int'(tx_pulse), int'(m_tp));
            check({m_tag, " phase"}, int'(phase), m_st);
        end
    end

    task automatic do_cfg(input logic [31:0] w);
        cfg_word = w;
        cfg_en   = 1'b1;
        @(negedge clk);
        check("R2 phase in cfg", int'(phase), 0);
        check("R2 strobes in cfg", int'({tq_strobe, sample_pulse, tx_pulse}), 0);
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    task automatic tx_period(output int n);
        do @(negedge clk); while (!tx_pulse);
        n = 0;
        do begin @(negedge clk); n++; end while (!tx_pulse);
    endtask

    task automatic tq_period(output int n);
        do @(negedge clk); while (!tq_strobe);
        n = 0;
        do begin @(negedge clk); n++; end while (!tq_strobe);
    endtask

    task automatic random_run(input logic [31:0] w, input int len);
        do_cfg(w);
        bus_rx = 1'b1;
        for (int i = 0; i < len; i++) begin
            bus_idle = (i < len / 4);
            if ($urandom_range(0, 6) == 0) bus_rx = ~bus_rx;
            @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 1'b0; cfg_en = 1'b0; cfg_word = '0; bus_rx = 1'b1; bus_idle = 1'b0;
        repeat (2) @(negedge clk);
        check("R12 phase", int'(phase), 0);
        check("R12 strobes", int'({tq_strobe, sample_pulse, tx_pulse}), 0);
        check("R12 rx_bit", int'(rx_bit), 1);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        begin
            int n;
            do_cfg(32'h0000_24C1);
            tq_period(n);
            check("R3 quantum period", n, 2);
            tx_period(n);
            check("R1 R4 bit period 0x24C1", n, 18);
            do_cfg(32'hFFFF_A4C1);
            tx_period(n);
            check("R1 upper bits ignored", n, 18);
            do_cfg(32'h0000_1200);
            tx_period(n);
            check("R4 bit period 0x1200", n, 6);
            do_cfg(32'h0000_7FC3);
            tx_period(n);
            check("R4 bit period 0x7FC3", n, 100);
        end
        // hard sync from idle, level held low afterwards
        do_cfg(32'h0000_24C1);
        bus_idle = 1'b1;
        repeat (30) @(negedge clk);
        bus_rx = 1'b0;
        repeat (60) @(negedge clk);
        bus_rx = 1'b1;
        bus_idle = 1'b0;
        random_run(32'h0000_24C1, 4000);
        random_run(32'h0000_1200, 3000);
        random_run(32'h0000_7FC3, 5000);
        random_run(32'h0000_33C0, 4000);
        random_run(32'h0000_2541, 4000);
        cmp_on = 1'b0;
        check("R7 edges seen", int'(n_edges > 0), 1);
        check("R8 hard syncs seen", int'(n_hs > 0), 1);
        check("R9 seg1 resyncs seen", int'(n_r1 > 0), 1);
        check("R10 seg2 resyncs seen", int'(n_r2 > 0), 1);
        check("R11 ignored edges seen", int'(n_ign > 0), 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule